// File: doc/BRIEF.md
# Modem Line Status Register with Change Flags

This block holds the modem status byte of a 16550-style serial port. Four modem input lines (carrier detect, ring, data-set-ready, clear-to-send) are brought into the clock domain through a multi-flop synchronizer. Their levels are kept in the upper nibble of the status byte. A sticky change flag per line is kept in the lower nibble. The ring line is the exception: its flag records only the end of a ring, which is a high-to-low transition. While any change flag is set and the modem-status interrupt enable is on, an interrupt request is raised towards the port's interrupt arbiter.

A read strobe from the register file returns the full byte in the same cycle and clears all four change flags on the following clock edge. If a line changes on that same edge, its flag stays set, so no event is lost. When the loopback bit of the modem control value is set, the register stops watching the external pins. It presents four of the modem control outputs as the line levels, and changes in those outputs produce the change flags in the normal way. Leaving or entering loopback counts as a level change wherever the presented level differs.

The read port is a plain strobe with combinational data. It has no back-pressure: a read always completes in the cycle in which it is strobed.

Top module: `modem_status_reg`

## Requirements
- R1: After reset the status byte reads 8'hB0 (carrier, data-set-ready and clear-to-send high, ring low, no change flags) and the interrupt request is low.
- R2: Outside loopback, a level on `line_i` (bit 3 carrier, bit 2 ring, bit 1 data-set-ready, bit 0 clear-to-send) appears in `msr_o[7:4]` in the same bit order exactly SYNC_STAGES+1 clock edges after it is applied.
- R3: A change in either direction of carrier, data-set-ready or clear-to-send sets change flag `msr_o[3]`, `msr_o[1]` or `msr_o[0]` respectively, on the edge where the new level appears.
- R4: Ring flag `msr_o[2]` is set when the ring level goes from 1 to 0, and is not set when it goes from 0 to 1.
- R5: Change flags stay set until a read. A cycle with `rd_i` high shows the current byte on `msr_o`, and the flags are cleared on the next edge.
- R6: A change whose new level lands on the same edge as a read's clear leaves its flag set after that edge.
- R7: `msi_irq_o` is high exactly when `msi_en_i` is high and at least one of `msr_o[3:0]` is set.
- R8: With `mcr_i[4]` high, the levels become carrier = `mcr_i[3]`, ring = `mcr_i[2]`, data-set-ready = `mcr_i[0]` and clear-to-send = `mcr_i[1]`, one edge after the control value is applied.
- R9: In loopback, activity on `line_i` changes neither the levels nor the change flags.
- R10: In loopback, changes in the mapped control bits set the change flags under the same rules as R3 and R4. This includes the level changes caused by leaving loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | 4 | External modem lines, asynchronous: [3] carrier, [2] ring, [1] data-set-ready, [0] clear-to-send |
| mcr_i | input | 5 | Modem control value: [0] DTR, [1] RTS, [2] OUT1, [3] OUT2, [4] loopback |
| msi_en_i | input | 1 | Modem-status interrupt enable |
| rd_i | input | 1 | Read strobe; the flags are cleared on the following edge |
| msr_o | output | 8 | Status byte: levels in [7:4], change flags in [3:0] |
| msi_irq_o | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a read whose clear lands on the very edge where a synchronized line change is registered. The stimulus counts edges from the moment a pin is driven. It raises the read strobe in the last cycle before the new level becomes visible, so the byte returned is still the old one and the flag must still be there afterwards. Loopback is entered and left with the mapped control bits set to differ from the current levels. This exercises the path where the change flags come from the control value, and the path where leaving loopback creates changes of its own.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int unsigned NLINES   = 4;
  localparam int unsigned LINE_CTS = 0;
  localparam int unsigned LINE_DSR = 1;
  localparam int unsigned LINE_RI  = 2;
  localparam int unsigned LINE_DCD = 3;

  localparam int unsigned MCR_W    = 5;
  localparam int unsigned MCR_DTR  = 0;
  localparam int unsigned MCR_RTS  = 1;
  localparam int unsigned MCR_OUT1 = 2;
  localparam int unsigned MCR_OUT2 = 3;
  localparam int unsigned MCR_LOOP = 4;

  localparam logic [NLINES-1:0] RESET_LEVELS = 4'b1011;

  typedef enum logic {
    EDGE_ANY  = 1'b0,
    EDGE_FALL = 1'b1
  } edge_mode_e;

  function automatic logic [NLINES-1:0] loop_levels(input logic [MCR_W-1:0] mcr);
    logic [NLINES-1:0] l;
    l[LINE_DCD] = mcr[MCR_OUT2];
    l[LINE_RI]  = mcr[MCR_OUT1];
    l[LINE_DSR] = mcr[MCR_DTR];
    l[LINE_CTS] = mcr[MCR_RTS];
    return l;
  endfunction
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_loop_mux.sv
module msr_loop_mux
  import msr_pkg::*;
(
  input  logic [NLINES-1:0] ext_i,
  input  logic [MCR_W-1:0]  mcr_i,
  output logic [NLINES-1:0] lvl_o
);
  always_comb begin
    if (mcr_i[MCR_LOOP]) lvl_o = loop_levels(mcr_i);
    else                 lvl_o = ext_i;
  end
endmodule

// File: rtl/msr_delta_cell.sv
module msr_delta_cell
  import msr_pkg::*;
#(
  parameter edge_mode_e MODE = EDGE_ANY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic old_i,
  input  logic new_i,
  input  logic clr_i,
  output logic flag_o
);
  logic hit;
  logic flag_q;

  if (MODE == EDGE_FALL) begin : g_fall
    assign hit = old_i & ~new_i;
  end else begin : g_any
    assign hit = old_i ^ new_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= (flag_q & ~clr_i) | hit;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
  import msr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] line_i,
  input  logic [4:0] mcr_i,
  input  logic       msi_en_i,
  input  logic       rd_i,
  output logic [7:0] msr_o,
  output logic       msi_irq_o
);
  logic [NLINES-1:0] ext_sync;
  logic [NLINES-1:0] lvl_next;
  logic [NLINES-1:0] lvl_q;
  logic [NLINES-1:0] flags;

  msr_sync #(
    .WIDTH  (NLINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(RESET_LEVELS)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (line_i),
    .q_o  (ext_sync)
  );

  msr_loop_mux u_mux (
    .ext_i(ext_sync),
    .mcr_i(mcr_i),
    .lvl_o(lvl_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= RESET_LEVELS;
    else        lvl_q <= lvl_next;
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    localparam edge_mode_e M = (i == LINE_RI) ? EDGE_FALL : EDGE_ANY;
    msr_delta_cell #(.MODE(M)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .old_i (lvl_q[i]),
      .new_i (lvl_next[i]),
      .clr_i (rd_i),
      .flag_o(flags[i])
    );
  end

  assign msr_o     = {lvl_q, flags};
  assign msi_irq_o = msi_en_i & (|flags);
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] mcr_i,
  input logic       msi_en_i,
  input logic       rd_i,
  input logic [7:0] msr_o,
  input logic       msi_irq_o
);
  // R7: request follows enable and flags
  a_r7_irq_match: assert property (@(posedge clk) disable iff (!rst_n)
    msi_irq_o == (msi_en_i && (msr_o[3:0] != 4'h0)));

  // R3: a level change always carries its flag (non-ring lines)
  a_r3_dcd_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_o[7] != $past(msr_o[7])) |-> msr_o[3]);
  a_r3_cts_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_o[4] != $past(msr_o[4])) |-> msr_o[0]);

  // R4: rising ring level never raises the ring flag
  a_r4_ring_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msr_o[6]) && !$past(msr_o[2])) |-> !msr_o[2]);

  // R5: flags are sticky without a read
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> ((msr_o[3:0] & $past(msr_o[3:0])) == $past(msr_o[3:0])));

  // R5: after a read with no level change the flags are clear
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> ((msr_o[7:4] != $past(msr_o[7:4])) || (msr_o[3:0] == 4'h0)));

  // R8: loopback mapping of the control bits
  a_r8_loop_map: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mcr_i[4])) |->
      (msr_o[7:4] == {$past(mcr_i[3]), $past(mcr_i[2]), $past(mcr_i[0]), $past(mcr_i[1])}));
endmodule

bind modem_status_reg msr_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mcr_i    (mcr_i),
  .msi_en_i (msi_en_i),
  .rd_i     (rd_i),
  .msr_o    (msr_o),
  .msi_irq_o(msi_irq_o)
);

// File: tb/sim_modem_status_reg.sv
`timescale 1ns/1ps
module sim_modem_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] line_i = 4'b1011;
  logic [4:0] mcr_i = 5'b0;
  logic       msi_en_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] msr_o;
  logic       msi_irq_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  modem_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .mcr_i(mcr_i),
    .msi_en_i(msi_en_i), .rd_i(rd_i), .msr_o(msr_o), .msi_irq_o(msi_irq_o)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: queue the expected byte, then strobe one read
  task automatic do_read(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_i = 1'b1;
    tick();
    rd_i = 1'b0;
  endtask

  // monitor: compare each read result away from the active edge
  always @(negedge clk) begin
    if (rst_n && rd_i && !done) begin
      if (exp_q.size() == 0) begin
        tests++;
        fails++;
        $display("FAIL scoreboard: unexpected read, got %h expected none", msr_o);
      end else begin
        check(tag_q.pop_front(), msr_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R1 reset byte", msr_o, 8'hB0);
    check("R1 reset irq", {7'b0, msi_irq_o}, 8'h00);
    rst_n = 1'b1;
    tick(2);
    do_read(8'hB0, "R1 idle read");

    // R2/R3: clear-to-send falls
    line_i = 4'b1010;
    tick(2);
    check("R2 not yet visible", msr_o, 8'hB0);
    tick();
    check("R2 level after sync", msr_o, 8'hA1);
    check("R7 irq masked", {7'b0, msi_irq_o}, 8'h00);
    msi_en_i = 1'b1;
    #1;
    check("R7 irq raised", {7'b0, msi_irq_o}, 8'h01);
    do_read(8'hA1, "R3 cts flag");
    do_read(8'hA0, "R5 cleared after read");
    check("R7 irq dropped", {7'b0, msi_irq_o}, 8'h00);

    // R4: ring rise then fall
    line_i = 4'b1110;
    tick(3);
    do_read(8'hE0, "R4 ring rise no flag");
    line_i = 4'b1010;
    tick(3);
    do_read(8'hA4, "R4 ring fall flag");
    do_read(8'hA0, "R4 ring flag cleared");

    // R3: carrier and data-set-ready fall together
    line_i = 4'b0000;
    tick(3);
    do_read(8'h0A, "R3 dcd dsr flags");
    do_read(8'h00, "R5 both cleared");

    // R5: flags persist
    line_i = 4'b0001;
    tick(10);
    check("R5 sticky flag", msr_o, 8'h11);
    do_read(8'h11, "R5 sticky read");

    // R6: change lands on the clearing edge
    line_i = 4'b0011;
    tick(2);
    do_read(8'h10, "R6 read before landing");
    check("R6 flag survives clear", msr_o, 8'h32);
    do_read(8'h32, "R6 read kept flag");
    do_read(8'h30, "R6 then cleared");

    // R8: loopback, OUT1 and DTR high
    mcr_i = 5'b10101;
    tick();
    do_read(8'h61, "R8 loop mapping");
    do_read(8'h60, "R8 flags cleared");

    // R9: external pins ignored in loopback
    line_i = 4'b1111;
    tick(5);
    check("R9 pins ignored", msr_o, 8'h60);
    check("R9 no irq", {7'b0, msi_irq_o}, 8'h00);

    // R10: OUT2 rises, OUT1 falls
    mcr_i = 5'b11001;
    tick();
    do_read(8'hAC, "R10 loop flags");
    do_read(8'hA0, "R10 cleared");

    // R10: leaving loopback shows the external levels
    mcr_i = 5'b00000;
    tick();
    do_read(8'hF1, "R10 exit loopback");

    tick(2);
    if (exp_q.size() != 0) begin
      tests++;
      fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule